// File: doc/BRIEF.md
# Byte ALU with Carry-Chain Flags

This block is the purely combinational arithmetic and logic unit of a small 8-bit processor datapath. Each cycle the sequencer gives it an operation code, two operand bytes (`opa` is the accumulator side and `opb` the memory or immediate side), the current carry flag and the current overflow flag. It returns the result byte, new values for the negative, overflow, zero and carry flags, and a write strobe that tells the datapath whether the result byte should be committed. Flags that an operation does not touch are passed through unchanged from the incoming carry and overflow, so the sequencer can always load all four flag outputs.

The single-operand operations act on `opb`: shifts, rotates through carry, increment and decrement. The sequencer routes either the accumulator or a fetched memory byte onto `opb` before it issues them. Subtraction and compare share one adder with the B input inverted. Compare and bit test update flags only. Decimal-mode correction is not part of this block, so a decimal-mode flag has no input here.

The operation codes are 0 add, 1 subtract, 2 AND, 3 OR, 4 XOR, 5 compare, 6 bit test, 7 shift left, 8 shift right, 9 rotate left, 10 rotate right, 11 increment and 12 decrement. Codes 13 to 15 are unassigned.

Top module: `alu8_core`

## Requirements
- R1: Add (code 0) gives res = (opa + opb + c_in) mod 256, and flag_c is the carry out of bit 7.
- R2: Subtract (code 1) gives res = (opa − opb − (1 − c_in)) mod 256. flag_c is 1 when no borrow occurred, which means opa − opb − (1 − c_in) ≥ 0.
- R3: Compare (code 5) ignores c_in. It sets flag_c when opa ≥ opb unsigned and flag_z when opa = opb, sets flag_n to bit 7 of (opa − opb) mod 256, and passes v_in to flag_v.
- R4: Bit test (code 6) sets flag_z when (opa AND opb) = 0, sets flag_n = opb[7] and flag_v = opb[6], and passes c_in to flag_c.
- R5: Shift left (code 7) writes 0 into bit 0 and sends opb[7] to flag_c. Shift right (code 8) writes 0 into bit 7 and sends opb[0] to flag_c.
- R6: Rotate left (code 9) fills bit 0 with c_in and takes flag_c from opb[7]. Rotate right (code 10) fills bit 7 with c_in and takes flag_c from opb[0].
- R7: Increment (code 11) and decrement (code 12) wrap modulo 256, so 0xFF+1 = 0x00 and 0x00−1 = 0xFF. flag_c = c_in and flag_v = v_in.
- R8: AND, OR and XOR (codes 2, 3, 4) combine opa and opb bitwise. flag_c = c_in and flag_v = v_in.
- R9: For add, flag_v is set exactly when opa[7] = opb[7] and res[7] ≠ opa[7]. For subtract, the same rule applies with opb replaced by its inverse. Shifts and rotates pass v_in to flag_v.
- R10: wr_en is 1 for codes 0–4 and 7–12, and 0 for compare, bit test and codes 13–15.
- R11: Codes 13–15 give res = opa, flag_c = c_in, flag_v = v_in and wr_en = 0.
- R12: For every code except bit test, flag_n = res[7] and flag_z = (res = 0). Compare presents its difference on res.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op | input | 4 | Operation code |
| opa | input | 8 | Accumulator-side operand |
| opb | input | 8 | Memory-side operand; the source for single-operand operations |
| c_in | input | 1 | Current carry flag |
| v_in | input | 1 | Current overflow flag |
| res | output | 8 | Result byte |
| flag_n | output | 1 | New negative flag |
| flag_v | output | 1 | New overflow flag |
| flag_z | output | 1 | New zero flag |
| flag_c | output | 1 | New carry flag |
| wr_en | output | 1 | Result should be stored |

## Verification
The hardest cases to reach are the carry and overflow boundaries of the shared adder. These are subtraction where the borrow ripples all the way through, compare against an equal operand, and signed overflow in both directions. Uniform random bytes hit these edges rarely. The stimulus therefore adds directed vectors at 0x00, 0x7F, 0x80 and 0xFF with both carry values. It also biases part of the random operands toward those values, so every code sees wrap, equality and sign changes under both incoming carry states.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    typedef enum logic [3:0] {
        OP_ADD = 4'd0,
        OP_SUB = 4'd1,
        OP_AND = 4'd2,
        OP_OR  = 4'd3,
        OP_XOR = 4'd4,
        OP_CMP = 4'd5,
        OP_BIT = 4'd6,
        OP_SHL = 4'd7,
        OP_SHR = 4'd8,
        OP_ROL = 4'd9,
        OP_ROR = 4'd10,
        OP_INC = 4'd11,
        OP_DEC = 4'd12
    } alu_op_e;

    typedef enum logic [1:0] {
        LG_AND = 2'd0,
        LG_OR  = 2'd1,
        LG_XOR = 2'd2
    } logic_sel_e;

    typedef enum logic [2:0] {
        UN_SHL = 3'd0,
        UN_SHR = 3'd1,
        UN_ROL = 3'd2,
        UN_ROR = 3'd3,
        UN_INC = 3'd4,
        UN_DEC = 3'd5
    } unary_sel_e;

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    input  logic             invert_b,
    output logic [WIDTH-1:0] sum,
    output logic             cout,
    output logic             ovf
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] b_eff;
    logic [WIDTH:0]   full;

    always_comb begin
        b_eff = invert_b ? ~b : b;
        full  = {1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, cin};
        sum   = full[WIDTH-1:0];
        cout  = full[WIDTH];
        ovf   = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);
    end

    // With B inverted and carry in set, the carry out means a >= b.
    always_comb begin
        if (invert_b && cin) begin
            assert_nob_borrow_R2: assert (cout == (a >= b))
                else $error("carry out disagrees with unsigned compare");
        end
    end

endmodule

// File: rtl/alu8_bitwise.sv
module alu8_bitwise
    import alu8_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic_sel_e       sel,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] out
);
    always_comb begin
        case (sel)
            LG_AND:  out = a & b;
            LG_OR:   out = a | b;
            LG_XOR:  out = a ^ b;
            default: out = '0;
        endcase
    end

    always_comb begin
        if (sel == LG_AND) begin
            assert_and_subset_R8: assert ((out & ~a) == '0)
                else $error("AND result has bits outside operand a");
        end
    end

endmodule

// File: rtl/alu8_unary.sv
module alu8_unary
    import alu8_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  unary_sel_e       sel,
    input  logic [WIDTH-1:0] x,
    input  logic             cin,
    output logic [WIDTH-1:0] out,
    output logic             cout
);
    localparam int MSB = WIDTH - 1;

    always_comb begin
        out  = x;
        cout = cin;
        case (sel)
            UN_SHL: begin out = {x[MSB-1:0], 1'b0}; cout = x[MSB]; end
            UN_SHR: begin out = {1'b0, x[MSB:1]};   cout = x[0];   end
            UN_ROL: begin out = {x[MSB-1:0], cin};  cout = x[MSB]; end
            UN_ROR: begin out = {cin, x[MSB:1]};    cout = x[0];   end
            UN_INC: out = x + 1'b1;
            UN_DEC: out = x - 1'b1;
            default: begin out = x; cout = cin; end
        endcase
    end

    always_comb begin
        if (sel == UN_SHL) begin
            assert_shl_fill_R5: assert (out[0] == 1'b0)
                else $error("shift left did not clear bit 0");
        end
        if (sel == UN_ROR) begin
            assert_ror_fill_R6: assert (out[MSB] == cin)
                else $error("rotate right did not fill top bit with carry");
        end
        if (sel == UN_INC || sel == UN_DEC) begin
            assert_step_carry_R7: assert (cout == cin)
                else $error("increment or decrement changed the carry");
        end
    end

endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [3:0]       op,
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    input  logic             c_in,
    input  logic             v_in,
    output logic [WIDTH-1:0] res,
    output logic             flag_n,
    output logic             flag_v,
    output logic             flag_z,
    output logic             flag_c,
    output logic             wr_en
);
    localparam int MSB = WIDTH - 1;

    alu_op_e    op_e;
    logic       as_invert;
    logic       as_cin;
    logic_sel_e lg_sel;
    unary_sel_e un_sel;

    logic [WIDTH-1:0] as_sum;
    logic             as_cout;
    logic             as_ovf;
    logic [WIDTH-1:0] lg_out;
    logic [WIDTH-1:0] un_out;
    logic             un_cout;

    assign op_e = alu_op_e'(op);

    // Operand routing for the three datapath units.
    always_comb begin
        as_invert = (op_e == OP_SUB) || (op_e == OP_CMP);
        as_cin    = (op_e == OP_CMP) ? 1'b1 : c_in;
        case (op_e)
            OP_OR:   lg_sel = LG_OR;
            OP_XOR:  lg_sel = LG_XOR;
            default: lg_sel = LG_AND;
        endcase
        case (op_e)
            OP_SHR:  un_sel = UN_SHR;
            OP_ROL:  un_sel = UN_ROL;
            OP_ROR:  un_sel = UN_ROR;
            OP_INC:  un_sel = UN_INC;
            OP_DEC:  un_sel = UN_DEC;
            default: un_sel = UN_SHL;
        endcase
    end

    alu8_addsub #(.WIDTH(WIDTH)) u_addsub (
        .a        (opa),
        .b        (opb),
        .cin      (as_cin),
        .invert_b (as_invert),
        .sum      (as_sum),
        .cout     (as_cout),
        .ovf      (as_ovf)
    );

    alu8_bitwise #(.WIDTH(WIDTH)) u_bitwise (
        .sel (lg_sel),
        .a   (opa),
        .b   (opb),
        .out (lg_out)
    );

    alu8_unary #(.WIDTH(WIDTH)) u_unary (
        .sel  (un_sel),
        .x    (opb),
        .cin  (c_in),
        .out  (un_out),
        .cout (un_cout)
    );

    // Result, flag and write-strobe selection.
    always_comb begin
        res    = opa;
        flag_v = v_in;
        flag_c = c_in;
        wr_en  = 1'b0;
        case (op_e)
            OP_ADD, OP_SUB: begin
                res    = as_sum;
                flag_v = as_ovf;
                flag_c = as_cout;
                wr_en  = 1'b1;
            end
            OP_CMP: begin
                res    = as_sum;
                flag_c = as_cout;
            end
            OP_AND, OP_OR, OP_XOR: begin
                res   = lg_out;
                wr_en = 1'b1;
            end
            OP_BIT: begin
                res    = lg_out;
                flag_v = opb[MSB-1];
            end
            OP_SHL, OP_SHR, OP_ROL, OP_ROR, OP_INC, OP_DEC: begin
                res    = un_out;
                flag_c = un_cout;
                wr_en  = 1'b1;
            end
            default: begin
                res = opa;
            end
        endcase
        flag_z = (res == '0);
        flag_n = (op_e == OP_BIT) ? opb[MSB] : res[MSB];
    end

    // Guards on the assembled outputs.
    always_comb begin
        if (op_e == OP_CMP || op_e == OP_BIT) begin
            assert_flags_only_R10: assert (!wr_en)
                else $error("compare or bit test asserted the write strobe");
        end
        if (op_e == OP_CMP) begin
            assert_cmp_order_R3: assert (flag_c == (opa >= opb) && flag_z == (opa == opb))
                else $error("compare flags do not match operand order");
        end
        if (op_e == OP_BIT) begin
            assert_bit_copy_R4: assert (flag_n == opb[MSB] && flag_v == opb[MSB-1] && flag_c == c_in)
                else $error("bit test flags not copied from operand b");
        end
        if (op > 4'd12) begin
            assert_unused_quiet_R11: assert (!wr_en && res == opa && flag_c == c_in && flag_v == v_in)
                else $error("unassigned code changed state");
        end
    end

endmodule

// File: tb/test_alu8_core.sv
module test_alu8_core;

    logic       clk = 1'b0;
    logic [3:0] op;
    logic [7:0] opa, opb, res;
    logic       c_in, v_in;
    logic       flag_n, flag_v, flag_z, flag_c, wr_en;

    int tests_run  = 0;
    int tests_fail = 0;

    always #10 clk = ~clk;

    alu8_core i_alu8_core (
        .op     (op),
        .opa    (opa),
        .opb    (opb),
        .c_in   (c_in),
        .v_in   (v_in),
        .res    (res),
        .flag_n (flag_n),
        .flag_v (flag_v),
        .flag_z (flag_z),
        .flag_c (flag_c),
        .wr_en  (wr_en)
    );

    // Expected bundle: {res, n, v, z, c, wr_en}
    function automatic logic [12:0] model(input logic [3:0] o, input logic [7:0] a,
                                          input logic [7:0] b, input logic c, input logic v);
        logic [7:0] r;
        logic       n, vo, z, co, we;
        int         d;
        r = a; vo = v; co = c; we = 1'b0;
        case (o)
            4'd0: begin
                d  = int'(a) + int'(b) + int'(c);
                r  = d[7:0]; co = (d > 255); we = 1'b1;
                vo = (a[7] == b[7]) && (r[7] != a[7]);
            end
            4'd1: begin
                d  = int'(a) - int'(b) - (1 - int'(c));
                r  = d[7:0]; co = (d >= 0); we = 1'b1;
                vo = (a[7] != b[7]) && (r[7] != a[7]);
            end
            4'd2: begin r = a & b; we = 1'b1; end
            4'd3: begin r = a | b; we = 1'b1; end
            4'd4: begin r = a ^ b; we = 1'b1; end
            4'd5: begin d = int'(a) - int'(b); r = d[7:0]; co = (a >= b); end
            4'd6: r = a & b;
            4'd7: begin r = b << 1; co = b[7]; we = 1'b1; end
            4'd8: begin r = b >> 1; co = b[0]; we = 1'b1; end
            4'd9: begin r = {b[6:0], c}; co = b[7]; we = 1'b1; end
            4'd10: begin r = {c, b[7:1]}; co = b[0]; we = 1'b1; end
            4'd11: begin r = b + 8'd1; we = 1'b1; end
            4'd12: begin r = b - 8'd1; we = 1'b1; end
            default: r = a;
        endcase
        z = (r == 8'h00);
        n = r[7];
        if (o == 4'd6) begin n = b[7]; vo = b[6]; end
        return {r, n, vo, z, co, we};
    endfunction

    function automatic string tag(input logic [3:0] o);
        case (o)
            4'd0: return "R1 R9";
            4'd1: return "R2 R9";
            4'd2, 4'd3, 4'd4: return "R8";
            4'd5: return "R3";
            4'd6: return "R4";
            4'd7, 4'd8: return "R5";
            4'd9, 4'd10: return "R6";
            4'd11, 4'd12: return "R7";
            default: return "R11";
        endcase
    endfunction

    task automatic apply(input logic [3:0] o, input logic [7:0] a, input logic [7:0] b,
                         input logic c, input logic v);
        logic [12:0] exp_v, act_v;
        @(negedge clk);
        op = o; opa = a; opb = b; c_in = c; v_in = v;
        #5;
        exp_v = model(o, a, b, c, v);
        act_v = {res, flag_n, flag_v, flag_z, flag_c, wr_en};
        tests_run++;
        if (act_v !== exp_v) begin
            tests_fail++;
            $display("FAIL %s R10 R12 op=%0d a=%h b=%h c=%b v=%b actual={res %h nvzc %b we %b} expected={res %h nvzc %b we %b}",
                     tag(o), o, a, b, c, v, act_v[12:5], act_v[4:1], act_v[0],
                     exp_v[12:5], exp_v[4:1], exp_v[0]);
        end
    endtask

    function automatic logic [7:0] pick();
        logic [7:0] edge_v [4] = '{8'h00, 8'h7F, 8'h80, 8'hFF};
        if ($urandom_range(3) == 0) return edge_v[$urandom_range(3)];
        return 8'($urandom);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        tests_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests_run, tests_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0A1B));
        op = 4'd0; opa = 8'h00; opb = 8'h00; c_in = 1'b0; v_in = 1'b0;
        // Idle inputs: add of zeros gives zero with Z set (R1 R12)
        apply(4'd0, 8'h00, 8'h00, 1'b0, 1'b0);
        // R1 R9: carry out and signed overflow edges
        apply(4'd0, 8'hFF, 8'h00, 1'b1, 1'b0);
        apply(4'd0, 8'h7F, 8'h01, 1'b0, 1'b0);
        apply(4'd0, 8'h80, 8'h80, 1'b0, 1'b1);
        // R2 R9: borrow from inverted carry
        apply(4'd1, 8'h00, 8'h00, 1'b0, 1'b0);
        apply(4'd1, 8'h00, 8'h00, 1'b1, 1'b1);
        apply(4'd1, 8'h80, 8'h01, 1'b1, 1'b0);
        // R3: compare equal, less and greater, carry in ignored
        apply(4'd5, 8'h42, 8'h42, 1'b0, 1'b1);
        apply(4'd5, 8'h10, 8'h20, 1'b1, 1'b0);
        apply(4'd5, 8'hFF, 8'h00, 1'b0, 1'b0);
        // R4: bit test copies operand bits
        apply(4'd6, 8'h0F, 8'hC0, 1'b1, 1'b0);
        apply(4'd6, 8'hFF, 8'h40, 1'b0, 1'b1);
        // R5 R6: shift fills and rotate through carry
        apply(4'd7, 8'h00, 8'h81, 1'b1, 1'b1);
        apply(4'd8, 8'h00, 8'h01, 1'b1, 1'b0);
        apply(4'd9, 8'h00, 8'h80, 1'b1, 1'b0);
        apply(4'd10, 8'h00, 8'h01, 1'b1, 1'b0);
        // R7: wraparound, carry untouched
        apply(4'd11, 8'h00, 8'hFF, 1'b1, 1'b1);
        apply(4'd12, 8'h00, 8'h00, 1'b0, 1'b0);
        // R8: logic ops keep carry and overflow
        apply(4'd2, 8'hF0, 8'h0F, 1'b1, 1'b1);
        apply(4'd4, 8'hAA, 8'hAA, 1'b1, 1'b0);
        // R11: unassigned codes
        apply(4'd13, 8'h80, 8'h12, 1'b1, 1'b1);
        apply(4'd15, 8'h00, 8'hFF, 1'b0, 1'b0);
        // Random mix over all codes (R1..R12)
        for (int k = 0; k < 3000; k++) begin
            apply(4'($urandom_range(15)), pick(), pick(), 1'($urandom), 1'($urandom));
        end
        $display("  [TB] %0d tests run, %0d failed", tests_run, tests_fail);
        $finish;
    end

endmodule